// File: doc/BRIEF.md
# Shared-Bus EPROM Bank Read Controller

This controller sits on the host side of a bank of byte-wide EPROMs that share one data bus. A host presents a 17-bit byte address with a valid/ready handshake. The two top address bits pick one of four devices. The remaining 15 bits go to the shared device address bus. The controller then drives the bank's two kinds of strobe. Each device has its own active-low chip select, taken from the decode. One active-low output-enable line is common to every device and goes low only for the data phase. All three device timings (address access, output-enable access and bus float delay) are given in picoseconds. They are converted to whole clock cycles by rounding up against a clock-period parameter. The controller counts those cycles before it samples the bus.

Once enough time has passed, the controller samples the bus, returns the byte with a single-cycle valid pulse and releases output enable. The selected chip stays selected after the read, so a following read to the same device only repeats the address and output-enable phases. A read to another device swaps the selects on the accept edge. Whenever a select or the output enable has just been released, the bus may still be driven by the previous device. For that reason output enable is held off until the float delay has elapsed.

Top module: `eprom_bank_rd`

## Requirements
- R1: While reset is held and in the cycle after it is released, every chip select is high (all ones), output enable is high, rdValid is low and reqReady is high.
- R2: A request is launched on a clock edge where reqValid and reqReady are both high. From that edge on, memCeN has exactly bit reqAddr[16:15] low and all other bits high, and memAddr equals reqAddr[14:0]. At most one chip select is ever low.
- R3: Output enable stays high during the launch edge. It falls no earlier than the edge at which ACC−OE cycles have elapsed since the launch edge, counted from launch and with at least 1. Here ACC and OE are the cycle counts of R9.
- R4: The byte is sampled on the first edge at which at least ACC cycles have elapsed since launch and at least OE cycles since output enable fell. rdData then holds the sampled memData, and rdValid is high for exactly that one following cycle.
- R5: Output enable returns high on the sampling edge. It stays high whenever the controller is idle.
- R6: Output enable never falls until at least DF cycles have elapsed since the most recent rising edge of any chip select or of output enable.
- R7: reqReady is high only while no read is in progress. It is low from the launch edge until the sampling edge. A new request can be launched on the edge right after the sampling edge.
- R8: Chip selects change only on a launch edge. After a read the selected device stays selected through idle cycles. A launch to a different device raises the old select and lowers the new one on the same edge.
- R9: ACC, OE and DF equal the access, output-enable and float times divided by the clock period, each rounded up to a whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host read request valid |
| reqAddr | input | 17 | Byte address; bits 16:15 select the device |
| reqReady | output | 1 | Controller can accept a request |
| rdValid | output | 1 | One-cycle pulse: rdData holds the read byte |
| rdData | output | 8 | Byte sampled from the bank |
| memAddr | output | 15 | Shared device address bus |
| memCeN | output | 4 | Active-low chip selects, one per device |
| memOeN | output | 1 | Active-low output enable shared by all devices |
| memData | input | 8 | Shared data bus from the devices |

## Verification
The reads are issued in several patterns, and each pattern isolates a different limit on when output enable may fall. A first read after reset and a same-device read after a long idle stretch are limited only by the address-to-enable lead. A same-device read issued straight after the previous sample is held back by the float gap that follows the last output-enable release. A read to a different device is held back by the float gap from the old chip-select release. The float time in the bench is set long enough that these three cases give three different sampling cycles. The bench models each device as returning a byte computed from its index and address, so data from the wrong device or address is visible. It also checks that the chip select is held across idle cycles.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  // whole cycles covering a time span, rounded up
  function automatic int cycCeil(input int tPs, input int clkPs);
    return (tPs + clkPs - 1) / clkPs;
  endfunction

  // control -> datapath strobes
  typedef struct packed {
    logic launch;   // latch address, switch chip selects, restart access count
    logic oeOn;     // drive shared output enable low
    logic capture;  // sample the bus, pulse rdValid, release output enable
  } ctlStrobes_t;

  // datapath -> control conditions
  typedef struct packed {
    logic oeWindow; // address old enough to open output enable
    logic gapFree;  // float delay since last strobe release has passed
    logic accDone;  // access time since launch met
    logic oeDone;   // output-enable time met
  } dpStatus_t;

endpackage

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dpStatus_t   stat,
  output logic        reqReady,
  output ctlStrobes_t strb
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2
  } rdState_t;

  rdState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strb         = '0;
    reqReady     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.launch = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stat.oeWindow && stat.gapFree) begin
          strb.oeOn = 1'b1;
          stateNext = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (stat.accDone && stat.oeDone) begin
          strb.capture = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/eprom_rd_dp.sv
module eprom_rd_dp
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int NUM_DEV = 4,
  parameter int ACC_CYC = 18,
  parameter int OE_CYC  = 9,
  parameter int DF_CYC  = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ctlStrobes_t                          strb,
  input  logic [ADDR_W-1:0]                    reqAddr,
  input  logic [DATA_W-1:0]                    memData,
  output logic [ADDR_W-$clog2(NUM_DEV)-1:0]    memAddr,
  output logic [NUM_DEV-1:0]                   memCeN,
  output logic                                 memOeN,
  output logic [DATA_W-1:0]                    rdData,
  output logic                                 rdValid,
  output dpStatus_t                            stat
);

  localparam int DEV_W   = $clog2(NUM_DEV);
  localparam int DEV_AW  = ADDR_W - DEV_W;
  localparam int OE_LEAD = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int DF_LD   = (DF_CYC > 0) ? DF_CYC - 1 : 0;
  localparam int ACC_W   = $clog2(ACC_CYC + 2);
  localparam int OE_W    = $clog2(OE_CYC + 2);
  localparam int GAP_W   = $clog2(DF_CYC + 2);

  localparam logic [ACC_W-1:0] ACC_MAX  = ACC_W'(ACC_CYC);
  localparam logic [ACC_W-1:0] LEAD_MIN = ACC_W'(OE_LEAD);
  localparam logic [OE_W-1:0]  OE_MAX   = OE_W'(OE_CYC);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(DF_LD);

  logic [DEV_W-1:0] reqDev, curDev;
  logic             ceOn;
  logic             ceRise;
  logic [ACC_W-1:0] addrAge;
  logic [OE_W-1:0]  oeAge;
  logic [GAP_W-1:0] gapCnt;

  assign reqDev = reqAddr[ADDR_W-1 -: DEV_W];
  // the currently selected chip is released when another one is chosen
  assign ceRise = strb.launch && ceOn && (reqDev != curDev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDev  <= '0;
      ceOn    <= 1'b0;
      memAddr <= '0;
    end else if (strb.launch) begin
      curDev  <= reqDev;
      ceOn    <= 1'b1;
      memAddr <= reqAddr[DEV_AW-1:0];
    end
  end

  // one registered select per device, decoded from the request
  for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_ce
    always_ff @(posedge clk) begin
      if (!rstN)            memCeN[gi] <= 1'b1;
      else if (strb.launch) memCeN[gi] <= (reqDev != DEV_W'(gi));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             memOeN <= 1'b1;
    else if (strb.capture) memOeN <= 1'b1;
    else if (strb.oeOn)    memOeN <= 1'b0;
  end

  // cycles elapsed since launch, seen value equals elapsed edges
  always_ff @(posedge clk) begin
    if (!rstN)                  addrAge <= '0;
    else if (strb.launch)       addrAge <= ACC_W'(1);
    else if (addrAge != ACC_MAX) addrAge <= addrAge + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          oeAge <= '0;
    else if (strb.oeOn)                 oeAge <= OE_W'(1);
    else if (!memOeN && oeAge != OE_MAX) oeAge <= oeAge + 1'b1;
  end

  // float gap: restarted by any strobe release
  always_ff @(posedge clk) begin
    if (!rstN)                         gapCnt <= '0;
    else if (ceRise || strb.capture)   gapCnt <= GAP_LOAD;
    else if (gapCnt != '0)             gapCnt <= gapCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      if (strb.capture) rdData <= memData;
    end
  end

  assign stat.oeWindow = (addrAge >= LEAD_MIN);
  assign stat.gapFree  = (gapCnt == '0);
  assign stat.accDone  = (addrAge >= ACC_MAX);
  assign stat.oeDone   = (oeAge >= OE_MAX);

endmodule

// File: rtl/eprom_bank_rd.sv
module eprom_bank_rd
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int NUM_DEV  = 4,
  parameter int CLK_PS   = 4000,
  parameter int T_ACC_PS = 70000,
  parameter int T_OE_PS  = 35000,
  parameter int T_DF_PS  = 30000
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic [ADDR_W-1:0]                 reqAddr,
  output logic                              reqReady,
  output logic                              rdValid,
  output logic [DATA_W-1:0]                 rdData,
  output logic [ADDR_W-$clog2(NUM_DEV)-1:0] memAddr,
  output logic [NUM_DEV-1:0]                memCeN,
  output logic                              memOeN,
  input  logic [DATA_W-1:0]                 memData
);

  localparam int ACC_CYC = cycCeil(T_ACC_PS, CLK_PS);
  localparam int OE_CYC  = cycCeil(T_OE_PS, CLK_PS);
  localparam int DF_CYC  = cycCeil(T_DF_PS, CLK_PS);

  ctlStrobes_t strb;
  dpStatus_t   stat;

  eprom_rd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .stat     (stat),
    .reqReady (reqReady),
    .strb     (strb)
  );

  eprom_rd_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_DEV (NUM_DEV),
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC),
    .DF_CYC  (DF_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .memData (memData),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .rdData  (rdData),
    .rdValid (rdValid),
    .stat    (stat)
  );

endmodule

// File: rtl/eprom_bank_rd_chk.sv
module eprom_bank_rd_chk
  import eprom_rd_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int CLK_PS   = 4000,
  parameter int T_ACC_PS = 70000,
  parameter int T_OE_PS  = 35000,
  parameter int T_DF_PS  = 30000
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               rdValid,
  input logic [NUM_DEV-1:0] memCeN,
  input logic               memOeN
);

  localparam int ACC  = cycCeil(T_ACC_PS, CLK_PS);
  localparam int OE   = cycCeil(T_OE_PS, CLK_PS);
  localparam int DF   = cycCeil(T_DF_PS, CLK_PS);
  localparam int LEAD = (ACC > OE) ? ACC - OE : 0;

  logic [NUM_DEV-1:0] prevCeN;
  logic               prevOeN;
  logic [15:0]        accAge, sinceRise, oeLow;
  logic               riseSeen, oeFell;

  assign riseSeen = (|(memCeN & ~prevCeN)) || (memOeN && !prevOeN);
  assign oeFell   = !memOeN && prevOeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCeN   <= '1;
      prevOeN   <= 1'b1;
      accAge    <= 16'hFFFF;
      sinceRise <= 16'hFFFF;
      oeLow     <= '0;
    end else begin
      prevCeN <= memCeN;
      prevOeN <= memOeN;
      if (reqValid && reqReady)  accAge <= 16'd1;
      else if (accAge != 16'hFFFF) accAge <= accAge + 16'd1;
      if (riseSeen)                   sinceRise <= 16'd1;
      else if (sinceRise != 16'hFFFF) sinceRise <= sinceRise + 16'd1;
      if (memOeN)                 oeLow <= '0;
      else if (oeLow != 16'hFFFF) oeLow <= oeLow + 16'd1;
    end
  end

  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCeN));

  assert_oe_with_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memCeN != '1));

  assert_oe_lead_R3: assert property (@(posedge clk) disable iff (!rstN)
    oeFell |-> (accAge >= 16'(LEAD + 1)));

  assert_access_met_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (accAge >= 16'(ACC + 1)) && (oeLow >= 16'(OE)));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> memOeN);

  assert_float_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    oeFell |-> (sinceRise >= 16'(DF)));

  assert_idle_oe_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memOeN);

  assert_busy_after_launch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_select_moves_on_launch_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memCeN) |-> $past(reqValid && reqReady));

endmodule

bind eprom_bank_rd eprom_bank_rd_chk #(
  .NUM_DEV  (NUM_DEV),
  .CLK_PS   (CLK_PS),
  .T_ACC_PS (T_ACC_PS),
  .T_OE_PS  (T_OE_PS),
  .T_DF_PS  (T_DF_PS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rdValid  (rdValid),
  .memCeN   (memCeN),
  .memOeN   (memOeN)
);

// File: tb/eprom_bank_rd_tb.sv
`timescale 1ns/1ps
module eprom_bank_rd_tb;

  localparam int CLK_PS   = 4000;
  localparam int T_ACC_PS = 70000;
  localparam int T_OE_PS  = 35000;
  localparam int T_DF_PS  = 60000;   // long float time so the gap binds
  // R9: bench's own rounding
  localparam int ACC  = (T_ACC_PS + CLK_PS - 1) / CLK_PS;   // 18
  localparam int OEC  = (T_OE_PS + CLK_PS - 1) / CLK_PS;    // 9
  localparam int DF   = (T_DF_PS + CLK_PS - 1) / CLK_PS;    // 15
  localparam int LEAD = (ACC > OEC) ? ((ACC - OEC > 0) ? ACC - OEC : 1) : 1;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [16:0] reqAddr = '0;
  logic        reqReady, rdValid, memOeN;
  logic [7:0]  rdData, memData;
  logic [14:0] memAddr;
  logic [3:0]  memCeN;

  always #2 clk = ~clk;   // 250 MHz

  eprom_bank_rd #(
    .CLK_PS(CLK_PS), .T_ACC_PS(T_ACC_PS), .T_OE_PS(T_OE_PS), .T_DF_PS(T_DF_PS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memData(memData)
  );

  function automatic logic [7:0] devByte(input int dev, input logic [14:0] lo);
    return lo[7:0] ^ {1'b0, lo[14:8]} ^ (8'(dev) * 8'h3B + 8'h11);
  endfunction

  // bank model: one selected device with output enable drives its byte
  always_comb begin
    int nSel;
    nSel = 0;
    memData = 8'h00;
    for (int i = 0; i < 4; i++) begin
      if (!memCeN[i]) begin
        nSel++;
        memData = devByte(i, memAddr);
      end
    end
    if (memOeN || nSel != 1) memData = 8'h00;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  typedef struct {
    logic [7:0] data;
    int         capEdge;
  } expItem_t;
  expItem_t expQ[$];

  int lastRise = -1000;
  int prevDev  = -1;

  // driver: launch one read, push its expected byte and sampling edge
  task automatic doRead(input int dev, input logic [14:0] lo);
    int a, oeStart, cap;
    expItem_t it;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = {2'(dev), lo};
    @(negedge clk);
    a = cyc;
    reqValid = 1'b0;
    check(!reqReady, "R7 busy after launch", int'(reqReady), 0);
    check(memCeN == ~(4'b0001 << dev), "R2 select decode", int'(memCeN), int'(~(4'b0001 << dev)));
    check(memAddr == lo, "R2 device address", int'(memAddr), int'(lo));
    check(memOeN, "R3 oe high at launch", int'(memOeN), 1);
    if (prevDev >= 0 && prevDev != dev) lastRise = a;   // R8 old select released
    oeStart = a + LEAD;                                  // R3
    if (lastRise + DF > oeStart) oeStart = lastRise + DF; // R6
    cap = a + ACC;                                       // R4
    if (oeStart + OEC > cap) cap = oeStart + OEC;
    it.data = devByte(dev, lo);
    it.capEdge = cap;
    expQ.push_back(it);
    lastRise = cap;                                      // R5 oe released at capture
    prevDev = dev;
  endtask

  // monitor: compare each returned byte against the scoreboard
  bit prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      check(!prevValid, "R4 single valid pulse", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected read data", int'(rdData), 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rdData == e.data, "R4 read data", int'(rdData), int'(e.data));
        check(cyc == e.capEdge, "R4/R6/R9 sample cycle", cyc, e.capEdge);
        check(memOeN, "R5 oe released at sample", int'(memOeN), 1);
      end
    end
    prevValid = rdValid;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memCeN == 4'hF, "R1 selects in reset", int'(memCeN), 15);
    check(memOeN, "R1 oe in reset", int'(memOeN), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN == 4'hF, "R1 selects after reset", int'(memCeN), 15);
    check(!rdValid, "R1 valid after reset", int'(rdValid), 0);
    check(reqReady, "R1 ready after reset", int'(reqReady), 1);

    doRead(0, 15'h0123);          // lead-limited
    doRead(0, 15'h7FFF);          // same device, gap after oe release
    repeat (30) @(negedge clk);
    check(memCeN == 4'b1110, "R8 select held while idle", int'(memCeN), 14);
    check(memOeN, "R5 oe high while idle", int'(memOeN), 1);
    doRead(2, 15'h1234);          // new device, gap after select release
    doRead(2, 15'h4321);
    doRead(3, 15'h0000);          // back-to-back device change
    repeat (40) @(negedge clk);
    doRead(3, 15'h5A5A);          // same device after idle: lead-limited
    doRead(1, 15'h7F00);
    doRead(1, 15'h00FF);

    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(memCeN == 4'b1101, "R8 last select held", int'(memCeN), 13);
    check(reqReady && memOeN, "R7 idle at end", int'(reqReady), 1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule